// File: doc/BRIEF.md
# Interconnect Transaction Timeout Monitor

This block sits beside an on-chip interconnect and watches the command handshake of each bus initiator. Each initiator is timed in two phases, each by its own timer. The first phase runs while a command is requested but not yet accepted. The second phase runs after the accept, until the initiator takes the response. Each phase is compared with its own programmable threshold, and a threshold of zero turns that comparison off. When a count reaches its threshold, the block sets a sticky status bit for that initiator and phase. It also raises a global error flag and emits a one-cycle error event.

A small write port loads the two thresholds and accepts three commands: clear the timeout state, clear the global flag, and start a self-test. A command acts only when the low nibble of the written value equals the key 4'hA. Each accepted command becomes a one-cycle internal pulse that takes effect on the following clock edge. Pending status is exported for every initiator and for every target, so software can see which agents still have a transaction in flight.

The self-test is run by a three-state sequencer:
- ST_IDLE to ST_RUN on a keyed start. This transition also wipes the timers.
- ST_RUN to ST_WIPE when every initiator's accept-phase bit is set (pass), or after four cycles in ST_RUN (fail).
- ST_WIPE to ST_IDLE unconditionally, clearing all timers and publishing the done and pass flags.

In ST_RUN every initiator is forced to wait, and the accept threshold is forced to 1. Events and the global flag are masked throughout ST_RUN.

Top module: `xact_timeout_mon`

## Requirements
- R1: After reset, all status bits, `glb_err`, `err_evt`, `init_active`, `tgt_active`, `st_done` and `st_pass` are 0, and both thresholds are 0.
- R2: An initiator waits for accept in a cycle where `req_vld` is 1 and `req_acc` is 0. Suppose the accept threshold (address 0) is T > 0 and the initiator waits for at least T consecutive cycles. Then its `sts_acc_to` bit is 1 from the edge after the T-th waiting cycle. With fewer waiting cycles, the bit stays 0.
- R3: A cycle with `req_vld` and `req_acc` both 1 is an accept. The cycles after an accept count as response waits until `rsp_acc` is sampled 1. Suppose the response threshold (address 1) is T > 0 and there are at least T such cycles. Then `sts_rsp_to` sets. With fewer cycles, it does not.
- R4: A threshold of 0 never sets the corresponding status bit, however long the wait.
- R5: Counters saturate at all ones and do not wrap. With the all-ones threshold, a status bit sets after exactly that many waiting cycles.
- R6: Status bits are sticky. `err_evt` pulses for one cycle, in the cycle the new bit reads 1, and only when a status bit goes from 0 to 1.
- R7: `glb_err` sets with every `err_evt`. It is cleared by a keyed write to address 3, which acts on the edge after the write. If a new violation lands on that same edge, `glb_err` stays 1.
- R8: A command write at address 2, 3 or 4 whose low nibble differs from 4'hA has no effect.
- R9: A keyed write to address 2 clears all status bits and counters and leaves `glb_err` unchanged.
- R10: `init_active[i]` is 1 while `req_vld[i]` is 1 or a response is still owed. `tgt_active[j]` sets on the edge that samples `tgt_acc[j]` and clears on the edge that samples `tgt_rsp[j]`.
- R11: A keyed write to address 4 runs the self-test. Afterwards `st_done` and `st_pass` are 1 and all status bits are 0. Neither `err_evt` nor `glb_err` is touched by the test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | N_INIT | Command request per initiator |
| req_acc | input | N_INIT | Command accept per initiator |
| rsp_acc | input | N_INIT | Response taken by initiator |
| tgt_acc | input | N_TGT | Target accepted a command |
| tgt_rsp | input | N_TGT | Target response completed |
| cfg_we | input | 1 | Write strobe |
| cfg_addr | input | 3 | 0/1 thresholds, 2 clear timeouts, 3 clear global, 4 self-test |
| cfg_wdata | input | CNT_W | Write data |
| sts_acc_to | output | N_INIT | Sticky accept-phase timeout |
| sts_rsp_to | output | N_INIT | Sticky response-phase timeout |
| glb_err | output | 1 | Global error flag |
| err_evt | output | 1 | One-cycle error event |
| init_active | output | N_INIT | Initiator has a pending transaction |
| tgt_active | output | N_TGT | Target has a pending transaction |
| st_done | output | 1 | Self-test finished |
| st_pass | output | 1 | Self-test passed |

## Verification
A clear of the global flag and a fresh timeout can fall on the same clock edge. To provoke this, the bench holds a request pending for three cycles against a threshold of 3. It times the keyed clear write so that the command pulse is live on exactly the edge where the status bit sets. The bench judges the result by `glb_err` and `err_evt` both reading 1 after that edge; a follow-up clear alone then must bring `glb_err` to 0. All other timing is swept exhaustively over thresholds and wait lengths on both initiators and both phases.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
    localparam logic [3:0] CMD_KEY      = 4'hA;
    localparam logic [2:0] A_THR_ACC    = 3'd0;
    localparam logic [2:0] A_THR_RSP    = 3'd1;
    localparam logic [2:0] A_CLR_TMO    = 3'd2;
    localparam logic [2:0] A_CLR_GLB    = 3'd3;
    localparam logic [2:0] A_SELFTEST   = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WIPE = 2'd2
    } st_state_t;
endpackage

// File: rtl/tmo_phase_timer.sv
module tmo_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [CNT_W-1:0] thr,
    output logic             sts,
    output logic             new_viol
);
    logic [CNT_W-1:0] cnt;
    logic             viol;

    always_comb begin
        viol     = (thr != '0) && (cnt >= thr);
        new_viol = viol && !sts && !clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sts <= 1'b0;
        end else if (clr) begin
            cnt <= '0;
            sts <= 1'b0;
        end else begin
            sts <= sts | viol;
            if (!run)
                cnt <= '0;
            else if (cnt != '1)
                cnt <= cnt + 1'b1;
        end
    end

    // R5: saturate instead of wrapping
    a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1 && run && !clr) |=> (cnt == '1));
    // R6: status is sticky
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sts && !clr) |=> sts);
    // R4: zero threshold never raises status
    a_r4_thr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (thr == '0 && !sts) |=> !sts);
endmodule

// File: rtl/tmo_selftest.sv
module tmo_selftest
    import tmo_pkg::*;
#(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic all_set,
    output logic force_on,
    output logic wipe,
    output logic done,
    output logic pass
);
    localparam int TW = (WIN > 1) ? $clog2(WIN) : 1;

    st_state_t       state, state_n;
    logic [TW-1:0]   tmr;
    logic            res_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tmr   <= '0;
            res_q <= 1'b0;
            done  <= 1'b0;
            pass  <= 1'b0;
        end else begin
            state <= state_n;
            unique case (state)
                ST_IDLE: begin
                    tmr <= '0;
                    if (start) begin
                        done  <= 1'b0;
                        pass  <= 1'b0;
                        res_q <= 1'b0;
                    end
                end
                ST_RUN: begin
                    tmr   <= tmr + 1'b1;
                    res_q <= all_set;
                end
                ST_WIPE: begin
                    done <= 1'b1;
                    pass <= res_q;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        state_n  = state;
        force_on = 1'b0;
        wipe     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                wipe = start;
                if (start) state_n = ST_RUN;
            end
            ST_RUN: begin
                force_on = 1'b1;
                if (all_set || tmr == TW'(WIN - 1)) state_n = ST_WIPE;
            end
            ST_WIPE: begin
                wipe    = 1'b1;
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // R11: wipe lasts one cycle and returns to idle
    a_r11_wipe_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WIPE) |=> (state == ST_IDLE));
    // R11: pass is only reported with done
    a_r11_pass_done: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);
endmodule

// File: rtl/xact_timeout_mon.sv
module xact_timeout_mon
    import tmo_pkg::*;
#(
    parameter int N_INIT = 2,
    parameter int N_TGT  = 2,
    parameter int CNT_W  = 8,
    parameter int ST_WIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_INIT-1:0] req_vld,
    input  logic [N_INIT-1:0] req_acc,
    input  logic [N_INIT-1:0] rsp_acc,
    input  logic [N_TGT-1:0]  tgt_acc,
    input  logic [N_TGT-1:0]  tgt_rsp,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [CNT_W-1:0]  cfg_wdata,
    output logic [N_INIT-1:0] sts_acc_to,
    output logic [N_INIT-1:0] sts_rsp_to,
    output logic              glb_err,
    output logic              err_evt,
    output logic [N_INIT-1:0] init_active,
    output logic [N_TGT-1:0]  tgt_active,
    output logic              st_done,
    output logic              st_pass
);
    logic [CNT_W-1:0]  thr_acc, thr_rsp, thr_acc_eff;
    logic              p_clr_tmo, p_clr_glb, p_start;
    logic              key_ok, force_on, wipe, clr_all;
    logic [N_INIT-1:0] rsp_pend, nv_acc, nv_rsp;

    assign key_ok = cfg_we && (cfg_wdata[3:0] == CMD_KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_acc   <= '0;
            thr_rsp   <= '0;
            p_clr_tmo <= 1'b0;
            p_clr_glb <= 1'b0;
            p_start   <= 1'b0;
        end else begin
            if (cfg_we && cfg_addr == A_THR_ACC) thr_acc <= cfg_wdata;
            if (cfg_we && cfg_addr == A_THR_RSP) thr_rsp <= cfg_wdata;
            p_clr_tmo <= key_ok && (cfg_addr == A_CLR_TMO);
            p_clr_glb <= key_ok && (cfg_addr == A_CLR_GLB);
            p_start   <= key_ok && (cfg_addr == A_SELFTEST);
        end
    end

    tmo_selftest #(.WIN(ST_WIN)) u_st (
        .clk(clk), .rst_n(rst_n), .start(p_start), .all_set(&sts_acc_to),
        .force_on(force_on), .wipe(wipe), .done(st_done), .pass(st_pass)
    );

    assign clr_all     = p_clr_tmo | wipe;
    assign thr_acc_eff = force_on ? CNT_W'(1) : thr_acc;

    for (genvar i = 0; i < N_INIT; i++) begin : g_init
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        rsp_pend[i] <= 1'b0;
            else if (req_vld[i] && req_acc[i]) rsp_pend[i] <= 1'b1;
            else if (rsp_acc[i])               rsp_pend[i] <= 1'b0;
        end
        assign init_active[i] = req_vld[i] | rsp_pend[i];

        tmo_phase_timer #(.CNT_W(CNT_W)) u_acc (
            .clk(clk), .rst_n(rst_n),
            .run(force_on | (req_vld[i] & ~req_acc[i])),
            .clr(clr_all), .thr(thr_acc_eff),
            .sts(sts_acc_to[i]), .new_viol(nv_acc[i])
        );
        tmo_phase_timer #(.CNT_W(CNT_W)) u_rsp (
            .clk(clk), .rst_n(rst_n),
            .run(rsp_pend[i] & ~rsp_acc[i]),
            .clr(clr_all), .thr(thr_rsp),
            .sts(sts_rsp_to[i]), .new_viol(nv_rsp[i])
        );
    end

    for (genvar j = 0; j < N_TGT; j++) begin : g_tgt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          tgt_active[j] <= 1'b0;
            else if (tgt_acc[j]) tgt_active[j] <= 1'b1;
            else if (tgt_rsp[j]) tgt_active[j] <= 1'b0;
        end
    end

    logic any_new;
    assign any_new = !force_on && (|nv_acc || |nv_rsp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_evt <= 1'b0;
            glb_err <= 1'b0;
        end else begin
            err_evt <= any_new;
            glb_err <= (glb_err && !p_clr_glb) || any_new;
        end
    end

    // R7: an event always comes with the global flag
    a_r7_evt_glb: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |-> glb_err);
    // R7: global flag only drops on a clear command
    a_r7_glb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_err && !p_clr_glb) |=> glb_err);
    // R11: no events during a forced self-test run
    a_r11_no_evt: assert property (@(posedge clk) disable iff (!rst_n)
        force_on |=> !err_evt);
endmodule

// File: tb/xact_timeout_mon_tb.sv
`timescale 1ns/1ps
module xact_timeout_mon_tb;
    localparam int NI = 2, NT = 2, CW = 4;

    logic          clk = 0, rst_n = 0;
    logic [NI-1:0] req_vld = 0, req_acc = 0, rsp_acc = 0;
    logic [NT-1:0] tgt_acc = 0, tgt_rsp = 0;
    logic          cfg_we = 0;
    logic [2:0]    cfg_addr = 0;
    logic [CW-1:0] cfg_wdata = 0;
    logic [NI-1:0] sts_acc_to, sts_rsp_to, init_active;
    logic [NT-1:0] tgt_active;
    logic          glb_err, err_evt, st_done, st_pass;

    int checks = 0, fails = 0, evt_cnt = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    xact_timeout_mon #(.N_INIT(NI), .N_TGT(NT), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_acc(req_acc),
        .rsp_acc(rsp_acc), .tgt_acc(tgt_acc), .tgt_rsp(tgt_rsp),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .sts_acc_to(sts_acc_to), .sts_rsp_to(sts_rsp_to), .glb_err(glb_err),
        .err_evt(err_evt), .init_active(init_active), .tgt_active(tgt_active),
        .st_done(st_done), .st_pass(st_pass)
    );

    always @(negedge clk) if (rst_n && err_evt) evt_cnt++;

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [CW-1:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 0;
        step();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        step(2);
        // R1 reset state
        chk("R1 sts", {sts_acc_to, sts_rsp_to}, 0);
        chk("R1 flags", {glb_err, err_evt, st_done, st_pass}, 0);
        chk("R1 active", {init_active, tgt_active}, 0);
        rst_n = 1;
        step();
        chk("R1 held", {sts_acc_to, sts_rsp_to, glb_err, err_evt}, 0);

        // R2 R6 accept-phase sweep
        for (int i = 0; i < NI; i++)
            for (int t = 1; t <= 5; t++)
                for (int w = 0; w <= 7; w++) begin
                    wr(3'd2, 4'hA);
                    wr(3'd0, CW'(t));
                    evt_cnt = 0;
                    req_vld[i] = 1;
                    step(w);
                    req_vld[i] = 0;
                    step(3);
                    chk("R2 sts_acc", sts_acc_to, (w >= t) ? (1 << i) : 0);
                    chk("R6 one evt", evt_cnt, (w >= t) ? 1 : 0);
                end
        wr(3'd0, 0);

        // R3 R10 response-phase sweep
        for (int i = 0; i < NI; i++)
            for (int t = 1; t <= 5; t++)
                for (int w = 0; w <= 7; w++) begin
                    wr(3'd2, 4'hA);
                    wr(3'd1, CW'(t));
                    evt_cnt = 0;
                    req_vld[i] = 1; req_acc[i] = 1;
                    step();
                    req_vld[i] = 0; req_acc[i] = 0;
                    chk("R10 init_active", init_active, 1 << i);
                    step(w);
                    rsp_acc[i] = 1;
                    step();
                    rsp_acc[i] = 0;
                    chk("R10 init idle", init_active, 0);
                    step(2);
                    chk("R3 sts_rsp", sts_rsp_to, (w >= t) ? (1 << i) : 0);
                    chk("R3 no acc", sts_acc_to, 0);
                    chk("R6 one evt", evt_cnt, (w >= t) ? 1 : 0);
                end
        wr(3'd1, 0);

        // R4 zero threshold
        wr(3'd2, 4'hA);
        evt_cnt = 0;
        req_vld = 2'b11;
        step(20);
        req_vld = 0;
        step(2);
        chk("R4 no sts", sts_acc_to, 0);
        chk("R4 no evt", evt_cnt, 0);

        // R5 saturation / all-ones threshold
        wr(3'd0, 4'hF);
        req_vld[0] = 1; step(14); req_vld[0] = 0; step(2);
        chk("R5 w14", sts_acc_to[0], 0);
        evt_cnt = 0;
        req_vld[0] = 1; step(40); req_vld[0] = 0; step(2);
        chk("R5 w40", sts_acc_to[0], 1);
        chk("R6 sticky one evt", evt_cnt, 1);
        wr(3'd2, 4'hA);
        req_vld[0] = 1; step(15); req_vld[0] = 0; step(2);
        chk("R5 w15", sts_acc_to[0], 1);

        // R8 R9 keys and clears
        chk("R7 glb set", glb_err, 1);
        wr(3'd2, 4'h5);
        chk("R8 bad key tmo", sts_acc_to[0], 1);
        wr(3'd2, 4'hA);
        chk("R9 cleared", sts_acc_to, 0);
        chk("R9 glb kept", glb_err, 1);
        wr(3'd3, 4'hB);
        chk("R8 bad key glb", glb_err, 1);
        wr(3'd3, 4'hA);
        chk("R7 glb cleared", glb_err, 0);

        // R7 collision: clear-global and new violation on the same edge
        wr(3'd0, 4'd3);
        req_vld[1] = 1;
        step();
        step();
        cfg_we = 1; cfg_addr = 3'd3; cfg_wdata = 4'hA;
        step();
        cfg_we = 0;
        step();
        chk("R7 collide glb", glb_err, 1);
        chk("R7 collide evt", err_evt, 1);
        req_vld[1] = 0;
        wr(3'd3, 4'hA);
        chk("R7 glb after", glb_err, 0);

        // R10 targets
        tgt_acc[1] = 1; step(); tgt_acc[1] = 0;
        chk("R10 tgt set", tgt_active, 2'b10);
        step(3);
        chk("R10 tgt hold", tgt_active, 2'b10);
        tgt_rsp[1] = 1; step(); tgt_rsp[1] = 0;
        chk("R10 tgt clr", tgt_active, 0);

        // R11 self-test
        wr(3'd4, 4'h3);
        step(8);
        chk("R8 bad key st", st_done, 0);
        evt_cnt = 0;
        wr(3'd4, 4'hA);
        step(8);
        chk("R11 done", st_done, 1);
        chk("R11 pass", st_pass, 1);
        chk("R11 sts wiped", {sts_acc_to, sts_rsp_to}, 0);
        chk("R11 no glb", glb_err, 0);
        chk("R11 no evt", evt_cnt, 0);

        finish_run();
    end
endmodule